// File: doc/BRIEF.md
# Interrupt Configuration and Priority Selector

This block holds the configuration of 32 interrupt sources and, every cycle, picks the most urgent one that is pending, enabled and belongs to a group that is switched on. Each source has an 8-bit priority, a 2-bit group code, a trigger mode and an enable bit. Software reaches all of this through a simple word-wide register port. Raw interrupt lines come in on `irq_in`. The block presents the winning ID and its priority on registered outputs, but only when that priority is more urgent than a programmable mask.

A lower priority value is more urgent. When two sources have the same priority, the lower ID wins. IDs 0 to 15 form the software-generated range. They are always edge-triggered, and their trigger bits cannot be changed. Edge sources latch a pending flag on a rising input. The flag stays set until software clears it. Level sources follow their input line directly.

Register map (word addresses, 32-bit data):

| Address | Write | Read |
|---|---|---|
| 0x00 | set enable bits (write 1 to set) | enable bits |
| 0x01 | clear enable bits (write 1 to clear) | enable bits |
| 0x02 | trigger mode (1 = edge, 0 = level) | trigger mode |
| 0x03 | clear edge pending flags (write 1 to clear) | pending bits |
| 0x04 | group enables: bit 0 Group 0, bit 1 Group 1 secure, bit 2 Group 1 non-secure | group enables |
| 0x05 | priority mask, bits 7:0 | priority mask |
| 0x06–0x07 | group codes | group codes |
| 0x08–0x0F | priorities | priorities |

The group codes pack 16 IDs per word: ID n uses address 0x06 + n/16, bits 2(n%16)+1 : 2(n%16). The priorities pack 4 IDs per word: ID n uses address 0x08 + n/4, bits 8(n%4)+7 : 8(n%4). Any other address reads as zero.

Top module: `irq_prio_select`

## Requirements
- R1: After reset the enables, pending flags, group enables, priority mask, priorities and group codes are all zero. The trigger register reads 0x0000FFFF and `sel_valid` is low.
- R2: A write to address 0x00 sets every enable bit whose data bit is 1 and leaves the others unchanged. Reads of 0x00 return the enable bits.
- R3: A write to address 0x01 clears every enable bit whose data bit is 1 and leaves the others unchanged. Reads of 0x01 also return the enable bits. A disabled source is never selected.
- R4: Trigger bits 15:0 always read 1 and ignore writes, so IDs 0–15 are edge-triggered. Bits 31:16 are writable: 1 selects edge mode and 0 selects level mode.
- R5: In edge mode, a rising input sets a pending flag. The flag holds after the input falls, until a 1 is written to its bit at address 0x03. In level mode, pending equals the input. Address 0x03 reads the pending bits.
- R6: Among sources that are pending, enabled and in an enabled group, the one with the numerically lowest priority value is selected.
- R7: Between candidates of equal priority, the lower ID is selected.
- R8: `sel_valid` is high only when the selected priority is strictly below the priority mask. A priority equal to the mask is not forwarded.
- R9: Group code 0 is gated by enable bit 0, code 1 by bit 1 and code 2 by bit 2. A source with code 3 is never forwarded.
- R10: The outputs are registered. A level input change shows one clock after the edge that samples it. An edge input shows two clocks after its rising sample.
- R11: The priority and group fields sit at the addresses and bit positions given in the map, and they read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Raw interrupt lines, one per ID |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| sel_valid | output | 1 | A forwarded interrupt is presented |
| sel_id | output | 5 | ID of the presented interrupt |
| sel_prio | output | 8 | Priority of the presented interrupt |

## Verification
The bench targets five corner cases.

- **Equal priorities.** It sets two sources to the same priority. A selector that used a non-strict compare would report the higher ID.
- **Mask equal to the priority.** It sets the mask exactly equal to the winning priority. An off-by-one compare would forward that interrupt.
- **Group gating and the reserved code.** It turns group enables on and off and uses the reserved group code. A wrong gate lets a disabled group's interrupt through.
- **Pending latch.** It pulses edge inputs, including one in the software-generated range, whose trigger bits it first tries to overwrite. A broken latch drops the interrupt once the pulse ends. A broken clear keeps it forever.
- **Output timing.** It samples the registered outputs cycle by cycle. This exposes a missing or extra pipeline stage.

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int SGI_NUM = 16,
  parameter int ADDR_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       sel_valid,
  output logic [$clog2(NUM_IRQ)-1:0] sel_id,
  output logic [PRIO_W-1:0]          sel_prio
);
  localparam int ID_W       = $clog2(NUM_IRQ);
  localparam int PRIO_PER_W = 32 / PRIO_W;
  localparam int GRP_PER_W  = 16;
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TRIG   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(5);
  localparam int A_GRP_BASE  = 6;
  localparam int A_PRIO_BASE = 8;
  localparam logic [NUM_IRQ-1:0] SGI_MASK = NUM_IRQ'((64'd1 << SGI_NUM) - 64'd1);

  logic [NUM_IRQ-1:0] en, trig_q, pend_e, irq_q;
  logic [PRIO_W-1:0]  prio [NUM_IRQ];
  logic [1:0]         grp  [NUM_IRQ];
  logic [2:0]         gen;
  logic [PRIO_W-1:0]  pmr;

  logic [NUM_IRQ-1:0] trig, pend, grp_ok, cand, pend_clr, rise;
  logic               found;
  logic [ID_W-1:0]    best_id;
  logic [PRIO_W-1:0]  best_p;

  assign trig     = trig_q | SGI_MASK;
  assign rise     = irq_in & ~irq_q;
  assign pend_clr = (reg_we && reg_addr == A_PEND) ? reg_wdata[NUM_IRQ-1:0] : '0;
  assign pend     = (trig & pend_e) | (~trig & irq_in);
  assign cand     = pend & en & grp_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= '0;
      trig_q <= '0;
      pend_e <= '0;
      irq_q  <= '0;
      gen    <= '0;
      pmr    <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_e <= ((pend_e & ~pend_clr) | rise) & trig;
      if (reg_we) begin
        case (reg_addr)
          A_EN_SET: en     <= en | reg_wdata[NUM_IRQ-1:0];
          A_EN_CLR: en     <= en & ~reg_wdata[NUM_IRQ-1:0];
          A_TRIG:   trig_q <= reg_wdata[NUM_IRQ-1:0] & ~SGI_MASK;
          A_CTRL:   gen    <= reg_wdata[2:0];
          A_MASK:   pmr    <= reg_wdata[PRIO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(A_PRIO_BASE + i / PRIO_PER_W);
    localparam logic [ADDR_W-1:0] GA = ADDR_W'(A_GRP_BASE + i / GRP_PER_W);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio[i] <= '0;
        grp[i]  <= '0;
      end else if (reg_we) begin
        if (reg_addr == PA) prio[i] <= reg_wdata[(i % PRIO_PER_W) * PRIO_W +: PRIO_W];
        if (reg_addr == GA) grp[i]  <= reg_wdata[(i % GRP_PER_W) * 2 +: 2];
      end
    end
    assign grp_ok[i] = (grp[i] != 2'd3) && gen[grp[i]];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN_SET, A_EN_CLR: reg_rdata[NUM_IRQ-1:0] = en;
      A_TRIG:             reg_rdata[NUM_IRQ-1:0] = trig;
      A_PEND:             reg_rdata[NUM_IRQ-1:0] = pend;
      A_CTRL:             reg_rdata[2:0]         = gen;
      A_MASK:             reg_rdata[PRIO_W-1:0]  = pmr;
      default: begin
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (reg_addr == ADDR_W'(A_PRIO_BASE + i / PRIO_PER_W))
            reg_rdata[(i % PRIO_PER_W) * PRIO_W +: PRIO_W] = prio[i];
          if (reg_addr == ADDR_W'(A_GRP_BASE + i / GRP_PER_W))
            reg_rdata[(i % GRP_PER_W) * 2 +: 2] = grp[i];
        end
      end
    endcase
  end

  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!found || prio[i] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_id    <= '0;
      sel_prio  <= '0;
    end else begin
      sel_valid <= found && (best_p < pmr);
      sel_id    <= (found && best_p < pmr) ? best_id : '0;
      sel_prio  <= (found && best_p < pmr) ? best_p  : '0;
    end
  end

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EN_SET) |=>
      ((en & $past(reg_wdata[NUM_IRQ-1:0])) == $past(reg_wdata[NUM_IRQ-1:0])));

  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EN_CLR) |=> ((en & $past(reg_wdata[NUM_IRQ-1:0])) == '0));

  p_sgi_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_TRIG) |-> (reg_rdata[SGI_NUM-1:0] == '1));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_prio < $past(pmr)));

  p_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((($past(cand) >> sel_id) & NUM_IRQ'(1)) != '0));
endmodule

// File: tb/irq_prio_select_tb_top.sv
module irq_prio_select_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sel_valid;
  logic [4:0]  sel_id;
  logic [7:0]  sel_prio;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit       v;
    bit [4:0] id;
    bit [7:0] pr;
    string    tag;
  } exp_t;
  exp_t sb_q[$];
  event mon_ev;

  always #10 clk = ~clk;

  irq_prio_select dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio));

  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (sel_valid !== e.v || (e.v && (sel_id !== e.id || sel_prio !== e.pr))) begin
          errors++;
          $display("FAIL %s: got valid=%0b id=%0d prio=%02h, expected valid=%0b id=%0d prio=%02h",
                   e.tag, sel_valid, sel_id, sel_prio, e.v, e.id, e.pr);
        end
      end
    end
  end

  task automatic expect_sel(input bit v, input bit [4:0] id, input bit [7:0] pr, input string tag);
    exp_t e;
    e.v = v; e.id = id; e.pr = pr; e.tag = tag;
    sb_q.push_back(e);
    -> mon_ev;
    #1;
  endtask

  task automatic wr(input bit [4:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input bit [4:0] a, input bit [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read addr %0h got %08h, expected %08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    irq_in[n] = 1'b1;
    @(negedge clk);
    irq_in[n] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_sel(0, 0, 0, "R1 output idle");
    rd_chk(5'h02, 32'h0000FFFF, "R1 trigger reset");
    rd_chk(5'h00, 32'h0, "R1 enable reset");
    rd_chk(5'h03, 32'h0, "R1 pending reset");
    rd_chk(5'h05, 32'h0, "R1 mask reset");
    rd_chk(5'h08, 32'h0, "R1 priority reset");

    wr(5'h02, 32'hFFFFFFFF); rd_chk(5'h02, 32'hFFFFFFFF, "R4 trigger all set");
    wr(5'h02, 32'h0);        rd_chk(5'h02, 32'h0000FFFF, "R4 SGI bits ignore write");
    wr(5'h02, 32'h00FF0000); rd_chk(5'h02, 32'h00FFFFFF, "R4 trigger mixed");

    wr(5'h00, 32'hF0); wr(5'h00, 32'h0F);
    rd_chk(5'h00, 32'hFF, "R2 set-enable accumulates");
    wr(5'h01, 32'h3C);
    rd_chk(5'h00, 32'hC3, "R3 clear-enable via set addr");
    rd_chk(5'h01, 32'hC3, "R3 clear-enable via clr addr");

    wr(5'h08, 32'h40302010); rd_chk(5'h08, 32'h40302010, "R11 priority readback");
    wr(5'h06, 32'h000000E4); rd_chk(5'h06, 32'h000000E4, "R11 group readback");
    wr(5'h06, 32'h0);

    for (int w = 8; w < 16; w++) wr(5'(w), 32'h80808080);
    wr(5'h00, 32'hFFFFFFFF);
    wr(5'h04, 32'h7);
    wr(5'h05, 32'hFF);
    rd_chk(5'h04, 32'h7, "R9 group enable readback");

    irq_in[24] = 1'b1; settle(); expect_sel(1, 24, 8'h80, "R5 level source");
    wr(5'h0F, 32'h80208080); irq_in[30] = 1'b1; settle();
    expect_sel(1, 30, 8'h20, "R6 lower value wins");
    wr(5'h0E, 32'h80802080); irq_in[25] = 1'b1; settle();
    expect_sel(1, 25, 8'h20, "R7 tie to lower ID");

    wr(5'h05, 32'h20); settle(); expect_sel(0, 0, 0, "R8 equal to mask blocked");
    wr(5'h05, 32'h21); settle(); expect_sel(1, 25, 8'h20, "R8 below mask forwarded");

    wr(5'h07, 32'h00080000); wr(5'h04, 32'h3); settle();
    expect_sel(1, 30, 8'h20, "R9 non-secure group off");
    wr(5'h07, 32'h30080000); wr(5'h04, 32'h7); settle();
    expect_sel(1, 25, 8'h20, "R9 non-secure group on");
    wr(5'h04, 32'h3); settle();
    expect_sel(0, 0, 0, "R9 code 3 never forwarded");
    wr(5'h05, 32'hFF); settle();
    expect_sel(1, 24, 8'h80, "R9 group 0 still on");

    irq_in[24] = 1'b0; irq_in[25] = 1'b0; irq_in[30] = 1'b0; settle();
    expect_sel(0, 0, 0, "R5 level drop");
    rd_chk(5'h03, 32'h0, "R5 pending empty");

    pulse(16); settle();
    expect_sel(1, 16, 8'h80, "R5 edge pending holds");
    rd_chk(5'h03, 32'h00010000, "R5 edge pending read");
    wr(5'h03, 32'h00010000); settle();
    expect_sel(0, 0, 0, "R5 edge pending cleared");
    rd_chk(5'h03, 32'h0, "R5 pending after clear");

    pulse(3); settle();
    expect_sel(1, 3, 8'h80, "R4 SGI edge latched");
    wr(5'h03, 32'h8); settle();
    expect_sel(0, 0, 0, "R4 SGI cleared");

    irq_in[24] = 1'b1; settle(); expect_sel(1, 24, 8'h80, "R3 before disable");
    wr(5'h01, 32'h01000000); settle(); expect_sel(0, 0, 0, "R3 disabled source blocked");
    wr(5'h00, 32'h01000000); settle(); expect_sel(1, 24, 8'h80, "R2 re-enabled");
    irq_in[24] = 1'b0; settle(); expect_sel(0, 0, 0, "R10 idle");

    @(negedge clk); irq_in[24] = 1'b1;
    expect_sel(0, 0, 0, "R10 level before edge");
    @(negedge clk); expect_sel(1, 24, 8'h80, "R10 level after one clock");
    irq_in[24] = 1'b0; settle();

    @(negedge clk); irq_in[17] = 1'b1;
    @(negedge clk); irq_in[17] = 1'b0;
    expect_sel(0, 0, 0, "R10 edge after one clock");
    @(negedge clk); expect_sel(1, 17, 8'h80, "R10 edge after two clocks");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule